// File: doc/BRIEF.md
# Source-Synchronous DDR Write Path

This block sits between the fabric write datapath and the memory pins. Each cycle it accepts one beat: a rising-half word, a falling-half word and a write enable. It sends the two halves out on one data bus, one half on each phase of the data clock. It also forwards a strobe that toggles once per enabled beat.

The data output stage runs on a data clock that leads the strobe clock by a quarter period. The strobe stage runs on the lagging clock. As a result, every strobe edge falls in the middle of a data half. Both quadrature clocks come from outside the block.

A build parameter selects how the falling half is taken in:
- In same-edge mode, an extra rising-edge register holds the falling half, so both halves are sampled on one rising edge of the data clock.
- In opposite-edge mode, the falling half is sampled directly on the falling edge of the data clock.

Top module: `ddr_wr_path`

## Requirements
- R1: While rst_ni is low, dq_oe_o and dqs_o are both low, whatever the other inputs are.
- R2: With wr_en_i high at rising edge k of clk270_i, dq_o equals the rise_data_i sampled at edge k for the whole high phase of clk270_i after edge k.
- R3: With wr_en_i high at rising edge k, dq_o equals the falling-half word of that beat for the whole low phase of clk270_i that follows. The latency is one data-clock cycle from sampling to the end of the beat.
- R4: In same-edge mode (MODE = EDGE_SAME, the default), fall_data_i is sampled at rising edge k. A change of fall_data_i between edge k and the next falling edge does not alter the falling half of the beat.
- R5: In opposite-edge mode (MODE = EDGE_OPPOSITE), the falling half is the value of fall_data_i at the falling edge of clk270_i that follows edge k.
- R6: dq_oe_o equals the wr_en_i sampled at the most recent rising edge of clk270_i, and holds that value for the full cycle.
- R7: For an enabled beat, dqs_o is high during the high phase of clk0_i that starts a quarter period after data edge k, and low during the low phase that follows. This places each strobe edge mid-way through a data half. dqs_o is low at every rising edge of clk270_i.
- R8: For a beat sampled with wr_en_i low, dqs_o stays low through both phases of clk0_i that belong to that beat, and dq_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Strobe clock (0 degree phase) |
| clk270_i | input | 1 | Data clock, leads clk0_i by a quarter period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Beat valid, sampled on rising edge of clk270_i |
| rise_data_i | input | DATA_W | Word sent during the high phase of the data clock |
| fall_data_i | input | DATA_W | Word sent during the low phase of the data clock |
| dq_o | output | DATA_W | DDR data bus |
| dq_oe_o | output | 1 | Data bus drive enable; low means tri-stated |
| dqs_o | output | 1 | Forwarded strobe |

## Verification
The two functions that can share a cycle are:
- latching the falling half of a beat;
- the arrival of the next beat's fall_data_i.

The bench provokes this by changing fall_data_i two units after a rising edge. That change lands before the falling edge that the opposite-edge variant samples on.

A same-edge instance and an opposite-edge instance run side by side on shared inputs. The reference model expects the old word from the first instance and the new word from the second. The strobe-gating edges are also checked: the first and last beat of a burst fall in the same clk0_i cycle as an enable change, and the model checks that dqs_o starts and stops exactly with those beats.

// File: rtl/ddr_wr_pkg.sv
`timescale 1ns/1ps
package ddr_wr_pkg;
  typedef enum logic {
    EDGE_OPPOSITE = 1'b0,
    EDGE_SAME     = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/ddr_oreg.sv
`timescale 1ns/1ps
module ddr_oreg
  import ddr_wr_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter edge_mode_e  MODE = EDGE_SAME
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= rise_i;
  end

  generate
    if (MODE == EDGE_SAME) begin : g_same
      // pre-register so both halves are taken on the rising edge
      logic [W-1:0] fall_pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_pre_q <= '0;
        else         fall_pre_q <= fall_i;
      end
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_q <= '0;
        else         fall_q <= fall_pre_q;
      end
      // R4
      same_edge_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> fall_q == $past(fall_i));
    end else begin : g_opp
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_q <= '0;
        else         fall_q <= fall_i;
      end
      // R5
      opp_edge_fall_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        1'b1 |=> fall_q == $past(fall_i));
    end
  endgenerate

  // output select follows the clock level: high phase rise, low phase fall
  assign q_o = clk_i ? rise_q : fall_q;
endmodule

// File: rtl/wr_data_lane.sv
`timescale 1ns/1ps
module wr_data_lane
  import ddr_wr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned GROUP_W = 8,
  parameter edge_mode_e  MODE    = EDGE_SAME
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] rise_i,
  input  logic [DATA_W-1:0] fall_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o
);
  localparam int unsigned GROUPS = DATA_W / GROUP_W;

  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= en_i;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    ddr_oreg #(
      .W   (GROUP_W),
      .MODE(MODE)
    ) u_oreg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rise_i(rise_i[g*GROUP_W +: GROUP_W]),
      .fall_i(fall_i[g*GROUP_W +: GROUP_W]),
      .q_o   (dq_o[g*GROUP_W +: GROUP_W])
    );
  end

  assign oe_o = oe_q;

  // R6
  oe_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> oe_q == $past(en_i));
endmodule

// File: rtl/wr_strobe_gen.sv
`timescale 1ns/1ps
module wr_strobe_gen
  import ddr_wr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic dqs_o
);
  // rising half carries the gate, falling half always returns low
  ddr_oreg #(
    .W   (1),
    .MODE(EDGE_OPPOSITE)
  ) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(en_i),
    .fall_i(1'b0),
    .q_o   (dqs_o)
  );
endmodule

// File: rtl/ddr_wr_path.sv
`timescale 1ns/1ps
module ddr_wr_path
  import ddr_wr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned GROUP_W = 8,
  parameter edge_mode_e  MODE    = EDGE_SAME
) (
  input  logic              clk0_i,
  input  logic              clk270_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] rise_data_i,
  input  logic [DATA_W-1:0] fall_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              dqs_o
);
  logic beat_en;

  wr_data_lane #(
    .DATA_W (DATA_W),
    .GROUP_W(GROUP_W),
    .MODE   (MODE)
  ) u_lane (
    .clk_i (clk270_i),
    .rst_ni(rst_ni),
    .en_i  (wr_en_i),
    .rise_i(rise_data_i),
    .fall_i(fall_data_i),
    .dq_o  (dq_o),
    .oe_o  (beat_en)
  );

  // gate crosses a quarter period from the leading data clock
  wr_strobe_gen u_strb (
    .clk_i (clk0_i),
    .rst_ni(rst_ni),
    .en_i  (beat_en),
    .dqs_o (dqs_o)
  );

  assign dq_oe_o = beat_en;

  // R7
  dqs_center_chk: assert property (@(posedge clk270_i) disable iff (!rst_ni)
    !dqs_o);

  // R8
  dqs_needs_oe_chk: assert property (@(negedge clk0_i) disable iff (!rst_ni)
    dqs_o |-> dq_oe_o);
endmodule

// File: tb/tb_ddr_wr_path.sv
`timescale 1ns/1ps
module tb_ddr_wr_path;
  import ddr_wr_pkg::*;

  localparam int DW = 16;

  typedef struct {
    bit          en;
    logic [DW-1:0] r;
    logic [DW-1:0] f;
    logic [DW-1:0] fo;
  } beat_t;

  logic          clk0, clk270, rst_n, wr_en;
  logic [DW-1:0] rise_d, fall_d;
  logic [DW-1:0] dq_s, dq_o2;
  logic          oe_s, oe_o2, dqs_s, dqs_o2;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  beat_t q[$];

  ddr_wr_path #(.DATA_W(DW), .GROUP_W(8), .MODE(EDGE_SAME)) dut (
    .clk0_i(clk0), .clk270_i(clk270), .rst_ni(rst_n), .wr_en_i(wr_en),
    .rise_data_i(rise_d), .fall_data_i(fall_d),
    .dq_o(dq_s), .dq_oe_o(oe_s), .dqs_o(dqs_s)
  );

  ddr_wr_path #(.DATA_W(DW), .GROUP_W(8), .MODE(EDGE_OPPOSITE)) dut_opp (
    .clk0_i(clk0), .clk270_i(clk270), .rst_ni(rst_n), .wr_en_i(wr_en),
    .rise_data_i(rise_d), .fall_data_i(fall_d),
    .dq_o(dq_o2), .dq_oe_o(oe_o2), .dqs_o(dqs_o2)
  );

  // 50 MHz: strobe clock rises at 10, data clock leads it by 5
  initial begin
    clk0 = 0;
    forever #10 clk0 = ~clk0;
  end
  initial begin
    clk270 = 0;
    #5;
    forever begin
      clk270 = 1; #10;
      clk270 = 0; #10;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic drive(input bit en, input logic [DW-1:0] r,
                       input logic [DW-1:0] f);
    beat_t b;
    @(negedge clk270); #1;
    wr_en = en; rise_d = r; fall_d = f;
    b.en = en; b.r = r; b.f = f; b.fo = f;
    q.push_back(b);
  endtask

  // fall word is replaced shortly after the sampling rising edge
  task automatic drive_late(input logic [DW-1:0] r, input logic [DW-1:0] f,
                            input logic [DW-1:0] f_new);
    beat_t b;
    @(negedge clk270); #1;
    wr_en = 1'b1; rise_d = r; fall_d = f;
    b.en = 1'b1; b.r = r; b.f = f; b.fo = f_new;
    q.push_back(b);
    @(posedge clk270); #2;
    fall_d = f_new;
  endtask

  // reference model: one beat per data-clock cycle, checked in four phases
  initial begin
    beat_t e;
    forever begin
      @(posedge clk270);
      if (q.size() > 0) begin
        e = q.pop_front();
        #3;
        chk(oe_s == e.en,  "R6 oe high phase", {31'd0, oe_s},  {31'd0, e.en});
        chk(oe_o2 == e.en, "R6 oe high phase opp", {31'd0, oe_o2}, {31'd0, e.en});
        if (e.en) begin
          chk(dq_s == e.r,  "R2 rise half", {16'd0, dq_s},  {16'd0, e.r});
          chk(dq_o2 == e.r, "R2 rise half opp", {16'd0, dq_o2}, {16'd0, e.r});
        end
        #5;
        chk(dqs_s == e.en,  "R7/R8 strobe high phase", {31'd0, dqs_s},  {31'd0, e.en});
        chk(dqs_o2 == e.en, "R7/R8 strobe high phase opp", {31'd0, dqs_o2}, {31'd0, e.en});
        #5;
        chk(oe_s == e.en, "R6 oe low phase", {31'd0, oe_s}, {31'd0, e.en});
        if (e.en) begin
          chk(dq_s == e.f,   "R3/R4 fall half same-edge", {16'd0, dq_s},  {16'd0, e.f});
          chk(dq_o2 == e.fo, "R3/R5 fall half opposite-edge", {16'd0, dq_o2}, {16'd0, e.fo});
        end
        #5;
        chk(!dqs_s,  "R7 strobe low phase", {31'd0, dqs_s},  32'd0);
        chk(!dqs_o2, "R7 strobe low phase opp", {31'd0, dqs_o2}, 32'd0);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 1; rise_d = 16'hFFFF; fall_d = 16'hFFFF;
    // R1: reset dominates an active enable
    #31;
    chk(!oe_s && !oe_o2, "R1 oe in reset", {30'd0, oe_s, oe_o2}, 32'd0);
    chk(!dqs_s && !dqs_o2, "R1 dqs in reset", {30'd0, dqs_s, dqs_o2}, 32'd0);
    #10;
    chk(!oe_s && !dqs_s, "R1 outputs in reset", {30'd0, oe_s, dqs_s}, 32'd0);
    #40;
    wr_en = 0;
    #15;
    rst_n = 1;

    // R8 idle
    repeat (3) drive(1'b0, 16'h1234, 16'h5678);
    // single beat framed by idle
    drive(1'b1, 16'hA5A5, 16'h5A5A);
    drive(1'b0, 16'h0000, 16'h0000);
    // burst with counting pattern
    for (int i = 0; i < 8; i++)
      drive(1'b1, 16'(16'h0100 + i), 16'(16'hF000 - i));
    // alternating extremes
    for (int i = 0; i < 4; i++)
      drive(1'b1, (i % 2) ? 16'hFFFF : 16'h0000, (i % 2) ? 16'h0000 : 16'hFFFF);
    drive(1'b0, 16'hDEAD, 16'hBEEF);
    // R4/R5 late fall change
    drive_late(16'h1111, 16'h2222, 16'h3333);
    drive_late(16'h4444, 16'h5555, 16'h6666);
    drive(1'b1, 16'h7777, 16'h8888);
    // walking one
    for (int i = 0; i < DW; i++)
      drive(1'b1, 16'(1 << i), ~16'(1 << i));
    repeat (3) drive(1'b0, 16'h0F0F, 16'hF0F0);
    while (q.size() > 0) @(posedge clk270);
    repeat (2) @(posedge clk270);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule